// File: doc/BRIEF.md
# Register Hazard Bubble Inserter

This block sits between instruction fetch and issue in a small in-order pipeline that has no operand forwarding. Each instruction entering it carries two source register indices and one destination index, each with its own enable flag. The instruction can also be marked as a label. A label is a pseudo-entry that goes downstream but never takes part in hazard tracking. The block remembers the destinations of the last two real instructions it issued. When a source of the incoming instruction names one of those registers, the block holds the instruction back. While it is held, the block sends zero, one or two no-op bubbles, enough for the earlier result to reach the register file.

Both sides of the block use valid/ready handshakes. A bubble goes out with valid set and every field zero, and the input is not accepted (ready low) while bubbles are being sent. A three-state controller sequences the work:
- FLOW: the input passes straight through. An instruction with a hazard causes the first bubble to go out from this state instead.
- WAIT: further bubbles go out while a counter runs down.
- ISSUE: the held instruction is released without being checked again.

The transitions are:
- FLOW→ISSUE: the first bubble is accepted and one bubble was needed.
- FLOW→WAIT: the first bubble is accepted and two were needed.
- WAIT→ISSUE: the last bubble is accepted.
- ISSUE→FLOW: the held instruction is accepted.

Top module: `hazard_bubble_gate`

## Requirements
- R1: A synchronous reset empties both history slots and zeroes the bubble counter. After reset, any instruction issues with no bubble, and `in_ready` follows `out_ready`.
- R2: A valid source equal to the destination of the most recent issued real instruction makes the block send exactly two bubbles before that instruction.
- R3: A valid source equal to the destination of the real instruction issued two places back, and not to the most recent one, makes the block send exactly one bubble.
- R4: Both sources are compared, and the bubble count is the larger of the two per-source counts.
- R5: When a real instruction issues, the older slot takes the previous newest destination and the newest slot takes the issuing instruction's destination.
- R6: A real instruction whose destination enable is 0 loads an empty marker into the newest slot. An empty marker matches no source.
- R7: Bubbles do not change the history.
- R8: A label (`in_label`=1) goes to the output unchanged with no bubbles, and it leaves the history unchanged.
- R9: A source whose enable flag is 0 never causes a bubble.
- R10: A bubble is presented with `out_valid`=1 and every output field zero, including `out_label`. While any bubble is pending, `in_ready` is 0. A bubble that `out_ready`=0 refuses stays on the output and is not counted.
- R11: A real instruction is presented at the output with all its fields unchanged, and it is taken when `in_ready` and `in_valid` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Incoming instruction accepted this cycle |
| in_label | input | 1 | Entry is a label pseudo-instruction |
| in_src0 | input | REG_W | First source register index |
| in_src0_en | input | 1 | First source in use |
| in_src1 | input | REG_W | Second source register index |
| in_src1_en | input | 1 | Second source in use |
| in_dst | input | REG_W | Destination register index |
| in_dst_en | input | 1 | Destination in use |
| in_payload | input | PAY_W | Opaque remaining instruction bits |
| out_valid | output | 1 | Output carries an instruction or a bubble |
| out_ready | input | 1 | Downstream takes the output |
| out_label | output | 1 | Output entry is a label |
| out_src0 | output | REG_W | First source index out |
| out_src0_en | output | 1 | First source enable out |
| out_src1 | output | REG_W | Second source index out |
| out_src1_en | output | 1 | Second source enable out |
| out_dst | output | REG_W | Destination index out |
| out_dst_en | output | 1 | Destination enable out |
| out_payload | output | PAY_W | Opaque bits out |

## Verification
A continuous stream of instructions covers several cases:
- A hit on the newest slot, a hit on the older slot, and hits on both slots through different operands. These separate the two-bubble, one-bubble and larger-of-two cases.
- Reads whose indices match the history but whose enable flags are clear. These show that the enables gate the comparison.
- A reader placed after a label, and a reader placed after an instruction that itself waited for bubbles. These show whether labels and bubbles wrongly age the history.
- Sequences of instructions with no destination. These show that empty markers push old destinations out of the history.

Directed runs hold `out_ready` low in the middle of a bubble sequence and while a held instruction is waiting, to show that bubbles are counted only when accepted. A reset in the middle of a stream shows that the history is cleared.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
    // number of source operands per instruction
    localparam int unsigned NSRC = 2;
    // bubbles owed for a hit in the newest / older history slot
    localparam int unsigned GAP_NEAR = 2;
    localparam int unsigned GAP_FAR  = 1;

    typedef enum logic [1:0] {
        ST_FLOW  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2
    } hbg_state_e;
endpackage

// File: rtl/hbg_history.sv
`timescale 1ns/1ps
module hbg_history #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_en,
    output logic             new_vld,
    output logic [REG_W-1:0] new_idx,
    output logic             old_vld,
    output logic [REG_W-1:0] old_idx
);
    logic             nv_q, ov_q;
    logic [REG_W-1:0] ni_q, oi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q <= 1'b0;
            ni_q <= '0;
            ov_q <= 1'b0;
            oi_q <= '0;
        end else if (shift_en) begin
            ov_q <= nv_q;
            oi_q <= ni_q;
            nv_q <= dst_en;
            ni_q <= dst_en ? dst : '0;
        end
    end

    assign new_vld = nv_q;
    assign new_idx = ni_q;
    assign old_vld = ov_q;
    assign old_idx = oi_q;

    AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(nv_q) && $stable(ni_q) && $stable(ov_q) && $stable(oi_q))); // R7
    AST_HIST_AGES: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (ov_q == $past(nv_q) && oi_q == $past(ni_q))); // R5
endmodule

// File: rtl/hbg_need.sv
`timescale 1ns/1ps
module hbg_need
    import hbg_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int BUB_W = 2
) (
    input  logic [NSRC-1:0][REG_W-1:0] src_idx,
    input  logic [NSRC-1:0]            src_en,
    input  logic                       new_vld,
    input  logic [REG_W-1:0]           new_idx,
    input  logic                       old_vld,
    input  logic [REG_W-1:0]           old_idx,
    output logic [BUB_W-1:0]           need
);
    logic [NSRC-1:0] hit_near, hit_far;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit_near[g] = src_en[g] && new_vld && (src_idx[g] == new_idx);
        assign hit_far[g]  = src_en[g] && old_vld && (src_idx[g] == old_idx);
    end

    always_comb begin
        if (|hit_near)
            need = BUB_W'(GAP_NEAR);
        else if (|hit_far)
            need = BUB_W'(GAP_FAR);
        else
            need = '0;
    end
endmodule

// File: rtl/hbg_ctrl.sv
`timescale 1ns/1ps
module hbg_ctrl
    import hbg_pkg::*;
#(
    parameter int BUB_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_label,
    input  logic [BUB_W-1:0] need,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             sel_bubble,
    output logic             shift_en
);
    hbg_state_e       state_q, state_d;
    logic [BUB_W-1:0] cnt_q, cnt_d;
    logic             hazard;

    assign hazard = in_valid && !in_label && (need != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FLOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FLOW: begin
                if (hazard && out_ready) begin
                    if (need == BUB_W'(1)) begin
                        state_d = ST_ISSUE;
                    end else begin
                        state_d = ST_WAIT;
                        cnt_d   = need - BUB_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (out_ready) begin
                    cnt_d = cnt_q - BUB_W'(1);
                    if (cnt_q == BUB_W'(1))
                        state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (in_valid && out_ready)
                    state_d = ST_FLOW;
            end
            default: begin
                state_d = ST_FLOW;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        sel_bubble = 1'b0;
        shift_en   = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                out_valid = in_valid;
                if (hazard) begin
                    sel_bubble = 1'b1;
                end else begin
                    in_ready = out_ready;
                    shift_en = in_valid && out_ready && !in_label;
                end
            end
            ST_WAIT: begin
                out_valid  = 1'b1;
                sel_bubble = 1'b1;
            end
            ST_ISSUE: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                shift_en  = in_valid && out_ready;
            end
            default: ;
        endcase
    end

    AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> (cnt_q != '0)); // R2
    AST_LAST_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && cnt_q == BUB_W'(1) && out_ready) |=> (state_q == ST_ISSUE && !sel_bubble)); // R2
endmodule

// File: rtl/hazard_bubble_gate.sv
`timescale 1ns/1ps
module hazard_bubble_gate
    import hbg_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_label,
    input  logic [REG_W-1:0] in_src0,
    input  logic             in_src0_en,
    input  logic [REG_W-1:0] in_src1,
    input  logic             in_src1_en,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_dst_en,
    input  logic [PAY_W-1:0] in_payload,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_label,
    output logic [REG_W-1:0] out_src0,
    output logic             out_src0_en,
    output logic [REG_W-1:0] out_src1,
    output logic             out_src1_en,
    output logic [REG_W-1:0] out_dst,
    output logic             out_dst_en,
    output logic [PAY_W-1:0] out_payload
);
    localparam int BUB_W = $clog2(GAP_NEAR + 1);

    logic [NSRC-1:0][REG_W-1:0] src_idx;
    logic [NSRC-1:0]            src_en;
    logic                       new_vld, old_vld;
    logic [REG_W-1:0]           new_idx, old_idx;
    logic [BUB_W-1:0]           need;
    logic                       sel_bubble, shift_en;

    assign src_idx = {in_src1, in_src0};
    assign src_en  = {in_src1_en, in_src0_en};

    hbg_history #(.REG_W(REG_W)) u_hist (
        .clk(clk), .rst(rst), .shift_en(shift_en),
        .dst(in_dst), .dst_en(in_dst_en),
        .new_vld(new_vld), .new_idx(new_idx),
        .old_vld(old_vld), .old_idx(old_idx)
    );

    hbg_need #(.REG_W(REG_W), .BUB_W(BUB_W)) u_need (
        .src_idx(src_idx), .src_en(src_en),
        .new_vld(new_vld), .new_idx(new_idx),
        .old_vld(old_vld), .old_idx(old_idx),
        .need(need)
    );

    hbg_ctrl #(.BUB_W(BUB_W)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_label(in_label),
        .need(need), .out_ready(out_ready), .in_ready(in_ready),
        .out_valid(out_valid), .sel_bubble(sel_bubble), .shift_en(shift_en)
    );

    always_comb begin
        if (sel_bubble) begin
            out_label   = 1'b0;
            out_src0    = '0;
            out_src0_en = 1'b0;
            out_src1    = '0;
            out_src1_en = 1'b0;
            out_dst     = '0;
            out_dst_en  = 1'b0;
            out_payload = '0;
        end else begin
            out_label   = in_label;
            out_src0    = in_src0;
            out_src0_en = in_src0_en;
            out_src1    = in_src1;
            out_src1_en = in_src1_en;
            out_dst     = in_dst;
            out_dst_en  = in_dst_en;
            out_payload = in_payload;
        end
    end

    AST_NEAR_STALLS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && in_valid && in_ready && !in_label && in_dst_en)
         && in_valid && !in_label && in_src0_en && in_src0 == $past(in_dst))
        |-> (!in_ready && out_valid)); // R2
    AST_BUBBLE_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sel_bubble && !out_ready) |=> (out_valid && !in_ready)); // R10
endmodule

// File: tb/hazard_bubble_gate_test.sv
`timescale 1ns/1ps
module hazard_bubble_gate_test;
    localparam int REG_W = 5;
    localparam int PAY_W = 16;
    localparam int NVEC  = 11;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_label;
    logic [REG_W-1:0] in_src0, in_src1, in_dst;
    logic in_src0_en, in_src1_en, in_dst_en;
    logic [PAY_W-1:0] in_payload;
    logic out_valid, out_ready, out_label;
    logic [REG_W-1:0] out_src0, out_src1, out_dst;
    logic out_src0_en, out_src1_en, out_dst_en;
    logic [PAY_W-1:0] out_payload;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hazard_bubble_gate #(.REG_W(REG_W), .PAY_W(PAY_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_label(in_label), .in_src0(in_src0), .in_src0_en(in_src0_en),
        .in_src1(in_src1), .in_src1_en(in_src1_en), .in_dst(in_dst),
        .in_dst_en(in_dst_en), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_label(out_label),
        .out_src0(out_src0), .out_src0_en(out_src0_en), .out_src1(out_src1),
        .out_src1_en(out_src1_en), .out_dst(out_dst), .out_dst_en(out_dst_en),
        .out_payload(out_payload)
    );

    // entry: {label, src0, src0_en, src1, src1_en, dst, dst_en, expected bubbles}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd3, 1'b1, 2'd0}, // R1 empty slots never hit
        {1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 5'd7, 1'b1, 2'd2}, // R2 newest hit
        {1'b0, 5'd0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'd1}, // R3 R5 older hit via src1
        {1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 5'd9, 1'b1, 2'd1}, // R6 newest empty, older 7
        {1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd4, 1'b1, 2'd0}, // R11 plain
        {1'b0, 5'd9, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 2'd2}, // R4 far on src0, near on src1
        {1'b0, 5'd4, 1'b0, 5'd4, 1'b0, 5'd5, 1'b1, 2'd0}, // R9 disabled sources
        {1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'd0}, // R8 label
        {1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 5'd0, 1'b0, 2'd2}, // R8 label kept 5 newest
        {1'b0, 5'd5, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 2'd1}, // R7 bubbles did not age
        {1'b0, 5'd5, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 2'd0}  // R6 both slots empty
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit out_zero();
        return !out_label && out_src0 == '0 && !out_src0_en && out_src1 == '0 &&
               !out_src1_en && out_dst == '0 && !out_dst_en && out_payload == '0;
    endfunction

    // drive one instruction; count bubbles; hold_cycles refuses the output at first
    task automatic send(input logic [20:0] v, input logic [PAY_W-1:0] pay,
                        input int hold_cycles, input string tag);
        int bub = 0;
        bit done = 0;
        in_label = v[20]; in_src0 = v[19:15]; in_src0_en = v[14];
        in_src1 = v[13:9]; in_src1_en = v[8]; in_dst = v[7:3]; in_dst_en = v[2];
        in_payload = pay; in_valid = 1'b1;
        for (int h = 0; h < hold_cycles; h++) begin
            out_ready = 1'b0;
            @(negedge clk);
            if (v[1:0] != 2'd0)
                chk(out_valid && !in_ready && out_zero(), "R10 refused bubble held", int'(in_ready), 0);
            @(posedge clk); #1;
        end
        out_ready = 1'b1;
        for (int c = 0; c < 8 && !done; c++) begin
            @(negedge clk);
            if (!in_ready) begin
                bub++;
                chk(out_valid && out_zero(), "R10 bubble encoding", int'(out_payload), 0);
            end else begin
                chk(out_valid && out_label == v[20] && out_src0 == v[19:15] &&
                    out_src0_en == v[14] && out_src1 == v[13:9] && out_src1_en == v[8] &&
                    out_dst == v[7:3] && out_dst_en == v[2] && out_payload == pay,
                    "R11 fields", int'(out_payload), int'(pay));
                done = 1;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        chk(bub == int'(v[1:0]), tag, bub, int'(v[1:0]));
    endtask

    initial begin
        #150000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_label = 1'b0; in_src0 = '0; in_src0_en = 1'b0;
        in_src1 = '0; in_src1_en = 1'b0; in_dst = '0; in_dst_en = 1'b0; in_payload = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && in_ready, "R1 reset state", int'(out_valid), 0);
        out_ready = 1'b0;
        #1;
        chk(!in_ready, "R1 ready follows out_ready", int'(in_ready), 0);
        out_ready = 1'b1;
        @(posedge clk); #1;

        for (int i = 0; i < NVEC; i++)
            send(VEC[i], PAY_W'(i + 1), 0, $sformatf("R2 R3 R4 bubble count vec %0d", i));

        // backpressure during a two-bubble wait
        send({1'b0, 5'd6, 1'b0, 5'd0, 1'b0, 5'd6, 1'b1, 2'd0}, 16'h0101, 0, "R11 setup");
        send({1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 5'd1, 1'b1, 2'd2}, 16'h0202, 3, "R10 counted bubbles");
        // one bubble on older slot after the stalled reader (6 now older)
        send({1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'd1}, 16'h0303, 0, "R3 after stall");

        // reset mid-stream clears history
        send({1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8, 1'b1, 2'd0}, 16'h0404, 0, "R11 setup");
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        send({1'b0, 5'd8, 1'b1, 5'd8, 1'b1, 5'd2, 1'b1, 2'd0}, 16'h0505, 0, "R1 history cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule